// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block sequences the two gates of one half-bridge phase. Each clock it reads the high-side and low-side on-commands and two comparator flags. Each flag shows whether one gate's gate-source voltage is above the turn-on threshold. For each gate it selects one of four current modes: source drive, sink drive, strong pulldown or hold. The analog stage turns that code into gate current.

The block has two timers. The drive window restarts on every toggle of either command. While the window is open, the gate that is turning on is sourced and the opposite gate is held off with a strong pulldown. The gate voltage never ends the source phase early. The outgoing gate is sunk until its comparator drops. Dead time then counts. The outgoing gate stays in sink mode through dead time as long as the window is open. Only after dead time has fully elapsed is the incoming gate granted. When the window closes, every gate falls back to hold. If the gate that should be on is still below the threshold at that moment, a sticky fault flag is raised.

Both lengths are cycle-count inputs sampled live. A value of 0 behaves like 1. All pins are plain control and status pins, so there is no stream handshake.

Top module: `gdseq_top`

## Requirements
- R1: After reset both mode outputs are hold (3'b000), the fault flag is 0 and no window or dead-time count is running.
- R2: A gate that was granted on and is no longer commanded gets sink drive (3'b010) while the window is open. It stays in the discharge phase until its comparator reads low. Dead time starts at the first edge that sees that comparator low.
- R3: Dead time lasts `dead_len` cycles (minimum 1). During it the outgoing gate keeps sink drive while the window is open. The incoming gate shows source drive only after the last dead-time cycle.
- R4: While one gate shows source drive (3'b001), the opposite gate shows strong pulldown (3'b011).
- R5: When a gate turns off and no gate is commanded on, neither gate shows strong pulldown. The outgoing gate goes from sink to hold, and both gates end in hold.
- R6: Source drive and strong pulldown last until the window closes, whatever the comparators show. The gates then show hold.
- R7: Every edge that sees either command differ from its value at the previous edge restarts the window. The window is then open for `win_len` cycles (minimum 1), starting in the cycle after that edge.
- R8: At the edge that closes the window, with no toggle at that edge, the fault flag sets if a gate is commanded on and its comparator reads low.
- R9: If dead time or discharge is still running after the window has closed, both gates show hold for the rest of it.
- R10: The fault flag stays set until `fault_clr` is high at an edge. A new fault detected at that same edge wins over the clear.
- R11: With both commands high, neither gate is treated as commanded on. Source drive never appears, and a granted gate is discharged.
- R12: A command change seen at an edge is reflected on the mode outputs right after that edge. The outputs depend only on registered state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_hi | input | 1 | High-side on-command |
| cmd_lo | input | 1 | Low-side on-command |
| hi_vgs_ok | input | 1 | High-side gate above threshold |
| lo_vgs_ok | input | 1 | Low-side gate above threshold |
| dead_len | input | CNT_W | Dead-time length in cycles |
| win_len | input | CNT_W | Drive-window length in cycles |
| fault_clr | input | 1 | Synchronous clear of the fault flag |
| mode_hi | output | 3 | High-side current mode |
| mode_lo | output | 3 | Low-side current mode |
| gd_fault | output | 1 | Sticky gate-drive fault |

## Verification
The mode outputs decode registered state only. A command or comparator value seen at one edge therefore shows on the modes right after that edge. The fault flag also updates at the edge that closes the window. The bench drives inputs and samples outputs at the falling edge. A cycle model in the bench is advanced once per cycle from the same inputs. Each sample is compared with the model state for the edge just passed. The model's gate voltages rise and fall with its own expected modes, and they feed the comparator flags. Discharge times, dead time and window closure therefore interleave in every order while dead and window lengths are swept.

// File: rtl/gdseq_pkg.sv
package gdseq_pkg;
  typedef enum logic [2:0] {
    GM_HOLD   = 3'b000,
    GM_SRC    = 3'b001,
    GM_SNK    = 3'b010,
    GM_STRONG = 3'b011
  } gate_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ON    = 2'd1,
    PH_DISCH = 2'd2,
    PH_DEAD  = 2'd3
  } phase_e;

  localparam int NUM_GATES = 2;
  localparam logic SIDE_HI = 1'b0;
  localparam logic SIDE_LO = 1'b1;
endpackage

// File: rtl/gdseq_window.sv
module gdseq_window #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             win_open,
  output logic             win_last
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [EXT_W-1:0] cnt_next_ext;

  assign cnt_next_ext = {1'b0, cnt_q} + EXT_W'(1);
  assign win_open     = run_q;
  assign win_last     = run_q && (cnt_next_ext >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (restart) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (win_last) run_q <= 1'b0;
      else          cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (run_q && cnt_q == '0)); // R7
endmodule

// File: rtl/gdseq_dead.sv
module gdseq_dead #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] len,
  output logic             dead_last
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_next_ext;

  assign cnt_next_ext = {1'b0, cnt_q} + EXT_W'(1);
  assign dead_last    = active && (cnt_next_ext >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!active)    cnt_q <= '0;
    else if (!dead_last) cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_DEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dead_last) |=> (cnt_q != '0)); // R3
endmodule

// File: rtl/gdseq_mode_dec.sv
module gdseq_mode_dec
  import gdseq_pkg::*;
#(
  parameter int GATE_ID = 0
) (
  input  phase_e     phase,
  input  logic       side,
  input  logic       win_open,
  output logic [2:0] mode
);
  logic own;
  assign own = (side == 1'(GATE_ID));

  always_comb begin
    mode = GM_HOLD;
    unique case (phase)
      PH_ON: begin
        if (win_open) mode = own ? GM_SRC : GM_STRONG;
      end
      PH_DISCH, PH_DEAD: begin
        if (win_open && own) mode = GM_SNK;
      end
      default: mode = GM_HOLD;
    endcase
  end
endmodule

// File: rtl/gdseq_top.sv
module gdseq_top
  import gdseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_hi,
  input  logic             cmd_lo,
  input  logic             hi_vgs_ok,
  input  logic             lo_vgs_ok,
  input  logic [CNT_W-1:0] dead_len,
  input  logic [CNT_W-1:0] win_len,
  input  logic             fault_clr,
  output logic [2:0]       mode_hi,
  output logic [2:0]       mode_lo,
  output logic             gd_fault
);
  logic                 cmd_hi_q, cmd_lo_q;
  logic                 toggle;
  logic [NUM_GATES-1:0] want;
  logic [NUM_GATES-1:0] vgs_ok;
  phase_e               phase_q, phase_d;
  logic                 side_q, side_d;
  logic                 win_open, win_last, dead_last;
  logic                 fault_q, fault_set;
  logic [2:0]           mode_vec [NUM_GATES];

  // Simultaneous commands count as both off.
  assign want[SIDE_HI] = cmd_hi & ~cmd_lo;
  assign want[SIDE_LO] = cmd_lo & ~cmd_hi;
  assign vgs_ok        = {lo_vgs_ok, hi_vgs_ok};
  assign toggle        = (cmd_hi ^ cmd_hi_q) | (cmd_lo ^ cmd_lo_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_hi_q <= 1'b0;
      cmd_lo_q <= 1'b0;
    end else begin
      cmd_hi_q <= cmd_hi;
      cmd_lo_q <= cmd_lo;
    end
  end

  gdseq_window #(.CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (toggle),
    .len      (win_len),
    .win_open (win_open),
    .win_last (win_last)
  );

  gdseq_dead #(.CNT_W(CNT_W)) u_dead (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (phase_q == PH_DEAD),
    .len       (dead_len),
    .dead_last (dead_last)
  );

  always_comb begin
    phase_d = phase_q;
    side_d  = side_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (want[SIDE_HI]) begin
          phase_d = PH_ON;
          side_d  = SIDE_HI;
        end else if (want[SIDE_LO]) begin
          phase_d = PH_ON;
          side_d  = SIDE_LO;
        end
      end
      PH_ON: begin
        if (!want[side_q]) phase_d = PH_DISCH;
      end
      PH_DISCH: begin
        if (want[side_q])        phase_d = PH_ON;
        else if (!vgs_ok[side_q]) phase_d = PH_DEAD;
      end
      PH_DEAD: begin
        if (dead_last) begin
          if (want[SIDE_HI]) begin
            phase_d = PH_ON;
            side_d  = SIDE_HI;
          end else if (want[SIDE_LO]) begin
            phase_d = PH_ON;
            side_d  = SIDE_LO;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      side_q  <= SIDE_HI;
    end else begin
      phase_q <= phase_d;
      side_q  <= side_d;
    end
  end

  assign fault_set = win_last && !toggle &&
                     ((want[SIDE_HI] && !vgs_ok[SIDE_HI]) ||
                      (want[SIDE_LO] && !vgs_ok[SIDE_LO]));

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= (fault_q & ~fault_clr) | fault_set;
  end

  assign gd_fault = fault_q;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_dec
    gdseq_mode_dec #(.GATE_ID(g)) u_dec (
      .phase    (phase_q),
      .side     (side_q),
      .win_open (win_open),
      .mode     (mode_vec[g])
    );
  end

  assign mode_hi = mode_vec[SIDE_HI];
  assign mode_lo = mode_vec[SIDE_LO];

  AST_DISCH_UNTIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DISCH && !want[side_q] && vgs_ok[side_q]) |=> (phase_q == PH_DISCH)); // R2
  AST_HI_SRC_LO_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi == 3'b001) |-> (mode_lo == 3'b011)); // R4
  AST_LO_SRC_HI_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lo == 3'b001) |-> (mode_hi == 3'b011)); // R4
  AST_SRC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_hi == 3'b001) || (mode_lo == 3'b001)) |-> win_open); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (gd_fault && !fault_clr) |=> gd_fault); // R10
  AST_BOTH_HIGH_NO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hi && cmd_lo) |=> (phase_q != PH_ON)); // R11
endmodule

// File: tb/test_gdseq_top.sv
module test_gdseq_top;
  localparam int CNT_W = 8;
  localparam int VMAX  = 5;
  localparam int VTH   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_hi = 1'b0, cmd_lo = 1'b0;
  logic hi_vgs_ok = 1'b0, lo_vgs_ok = 1'b0;
  logic [CNT_W-1:0] dead_len = 8'd2, win_len = 8'd4;
  logic fault_clr = 1'b0;
  logic [2:0] mode_hi, mode_lo;
  logic gd_fault;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state (value after the most recent rising edge)
  int m_ph, m_side, m_wcnt, m_dcnt;
  bit m_wrun, m_fault, m_ph_h, m_ph_l;
  int vh, vl;
  bit stuck_h;

  always #10 clk = ~clk;

  gdseq_top #(.CNT_W(CNT_W)) i_gdseq_top (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .hi_vgs_ok(hi_vgs_ok), .lo_vgs_ok(lo_vgs_ok),
    .dead_len(dead_len), .win_len(win_len), .fault_clr(fault_clr),
    .mode_hi(mode_hi), .mode_lo(mode_lo), .gd_fault(gd_fault)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // phase: 0 idle, 1 on, 2 discharge, 3 dead; side 0 hi, 1 lo
  function automatic int emode(input int g);
    if (m_ph == 1 && m_wrun) return (m_side == g) ? 1 : 3;
    if ((m_ph == 2 || m_ph == 3) && m_wrun && m_side == g) return 2;
    return 0;
  endfunction

  function automatic string tag_of(input bit both);
    if (both) return "R11";
    case (m_ph)
      1: return m_wrun ? "R4" : "R6";
      2: return m_wrun ? "R2" : "R9";
      3: return m_wrun ? "R3" : "R9";
      default: return "R5";
    endcase
  endfunction

  function automatic int nz(input int x);
    return (x < 1) ? 1 : x;
  endfunction

  task automatic model_reset();
    m_ph = 0; m_side = 0; m_wcnt = 0; m_dcnt = 0;
    m_wrun = 0; m_fault = 0; m_ph_h = 0; m_ph_l = 0;
    vh = 0; vl = 0;
  endtask

  // Called at a falling edge: compare, slew gates, drive, advance model.
  task automatic step(input bit nh, input bit nl, input bit clr);
    int eh, el;
    bit wh, wl, tog, wlast, dlast, fset, ah, al;
    int nph, nside;
    eh = emode(0); el = emode(1);
    check(tag_of(cmd_hi && cmd_lo), int'(mode_hi), eh);
    check(tag_of(cmd_hi && cmd_lo), int'(mode_lo), el);
    check(fault_clr ? "R10" : "R8", int'(gd_fault), int'(m_fault));
    // gate voltages respond to the expected modes
    if (eh == 1) vh = vh + 1; else if (eh == 2) vh = vh - 1; else if (eh == 3) vh = vh - 2;
    if (el == 1) vl = vl + 1; else if (el == 2) vl = vl - 1; else if (el == 3) vl = vl - 2;
    if (vh < 0) vh = 0;
    if (vl < 0) vl = 0;
    if (vh > (stuck_h ? 2 : VMAX)) vh = stuck_h ? 2 : VMAX;
    if (vl > VMAX) vl = VMAX;
    ah = (vh >= VTH); al = (vl >= VTH);
    cmd_hi = nh; cmd_lo = nl; fault_clr = clr;
    hi_vgs_ok = ah; lo_vgs_ok = al;
    // next state
    wh = nh && !nl; wl = nl && !nh;
    tog = (nh != m_ph_h) || (nl != m_ph_l);
    wlast = m_wrun && (m_wcnt + 1 >= int'(win_len));
    dlast = (m_ph == 3) && (m_dcnt + 1 >= int'(dead_len));
    fset = wlast && !tog && ((wh && !ah) || (wl && !al));
    nph = m_ph; nside = m_side;
    case (m_ph)
      0: if (wh) begin nph = 1; nside = 0; end else if (wl) begin nph = 1; nside = 1; end
      1: if (!(m_side == 0 ? wh : wl)) nph = 2;
      2: if (m_side == 0 ? wh : wl) nph = 1;
         else if (!(m_side == 0 ? ah : al)) nph = 3;
      default: if (dlast) begin
        if (wh) begin nph = 1; nside = 0; end
        else if (wl) begin nph = 1; nside = 1; end
        else nph = 0;
      end
    endcase
    if (m_ph != 3) m_dcnt = 0; else if (!dlast) m_dcnt++;
    if (tog) begin m_wrun = 1; m_wcnt = 0; end
    else if (m_wrun) begin if (wlast) m_wrun = 0; else m_wcnt++; end
    m_fault = (m_fault && !clr) || fset;
    m_ph = nph; m_side = nside; m_ph_h = nh; m_ph_l = nl;
    @(negedge clk);
  endtask

  initial begin
    int src_cnt;
    bit first_src;
    logic [7:0] lfsr;
    bit ch, cl;
    int sweep_i;
    stuck_h = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", int'(mode_hi), 0);
    check("R1", int'(mode_lo), 0);
    check("R1", int'(gd_fault), 0);

    // R12 and R7: hi on from idle, source one edge later, lasting win_len cycles
    step(1, 0, 0);
    check("R12", int'(mode_hi), 1);
    src_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      if (mode_hi == 3'b001) src_cnt++;
      step(1, 0, 0);
    end
    check("R7", src_cnt, nz(int'(win_len)));

    // R7: toggle restarts the window; off-then-back-on gives a fresh window
    step(0, 0, 0);
    for (int k = 0; k < 12; k++) step(0, 0, 0);
    step(0, 1, 0);
    first_src = 0; src_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (mode_lo == 3'b001) src_cnt++;
      step(0, 1, 0);
    end
    check("R7", src_cnt, nz(int'(win_len)));

    // R8/R10: stuck high gate raises fault, clear drops it, fault persists otherwise
    stuck_h = 1;
    step(1, 0, 0);
    for (int k = 0; k < 25; k++) step(1, 0, 0);
    check("R8", int'(gd_fault), 1);
    step(1, 0, 1);
    check("R10", int'(gd_fault), 0);
    stuck_h = 0;
    step(0, 0, 0);
    for (int k = 0; k < 15; k++) step(0, 0, 0);

    // sweep over dead and window lengths, stuck gate on/off
    lfsr = 8'hA5;
    sweep_i = 0;
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d <= 3; d++) begin
        for (int w = 0; w < 4; w++) begin
          stuck_h = bit'(s);
          dead_len = 8'(d);
          win_len = (w == 0) ? 8'd1 : (w == 1) ? 8'd3 : (w == 2) ? 8'd6 : 8'd14;
          ch = cmd_hi; cl = cmd_lo;
          for (int k = 0; k < 80; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[2:0] == 3'd0) begin ch = lfsr[3]; cl = lfsr[4]; end
            sweep_i++;
            step(ch, cl, (sweep_i % 37) == 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule